// File: doc/BRIEF.md
# RTC Interrupt Pending and Wake Controller

This block merges the timekeeper's event strobes (a day-rollover event and an interval alarm event, or any number of such sources) into one latched interrupt request for the processor. It also raises a wake request toward the power controller. The request reaches the processor only while the enable input is high. The latch itself ignores the enable, so an event that arrives while interrupts are masked is kept and appears as soon as the mask is lifted. Only the processor's vector acknowledge clears the latch.

Each event source also keeps its own sticky flag. Software reads the flag to learn which source fired and clears it with a dedicated clear strobe. The vector acknowledge leaves these flags untouched. The wake output follows the sleep indication whenever an interrupt is latched. As a result, every attempt to go back to sleep is answered with a fresh wake until the interrupt has been serviced.

Top module: `rtc_irq_wake`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, irq_req_o is 0, wake_o is 0 and every bit of flag_o is 0.
- R2: A cycle with any bit of evt_i high latches the pending interrupt at the following clock edge.
- R3: irq_req_o equals the latched pending state ANDed with irq_en_i in the same cycle. A pending interrupt held while irq_en_i is low appears on irq_req_o in the first cycle irq_en_i is high.
- R4: irq_ack_i sampled high while irq_req_o is high and no event is present clears the pending state at that clock edge.
- R5: irq_ack_i has no effect while irq_en_i is low or while nothing is pending.
- R6: If an event and an effective acknowledge occur in the same cycle, the pending state stays set.
- R7: wake_o is a register. It is 1 in the cycle after a cycle in which sleep_i is high and the next pending state is 1. Otherwise it is 0, so it is 0 after any cycle with sleep_i low.
- R8: While an interrupt stays pending, each cycle of sleep_i high produces wake_o high in the next cycle. Once the interrupt has been acknowledged, sleep_i high produces no wake.
- R9: flag_o[i] is set by evt_i[i] and cleared only by flag_clr_i[i]. If both are high in the same cycle, the set wins. irq_ack_i does not change any flag.
- R10: Events on several sources in the same cycle create a single pending interrupt, which one acknowledge clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_SRC | Event strobes, bit 0 day rollover, bit 1 interval alarm |
| flag_clr_i | input | NUM_SRC | Per-source flag clear strobes |
| irq_en_i | input | 1 | Interrupt enable |
| irq_ack_i | input | 1 | Processor vector acknowledge |
| sleep_i | input | 1 | Power controller requests or holds sleep |
| irq_req_o | output | 1 | Interrupt request to the processor |
| wake_o | output | 1 | Wake request to the power controller |
| flag_o | output | NUM_SRC | Sticky per-source event flags |

## Verification
A lost or stuck pending bit shows on irq_req_o in the very cycle the enable is high. It also shows on wake_o one cycle after sleep is requested. A pending bit that never clears keeps waking a system that has already serviced the interrupt. A pending bit cleared by a masked or spurious acknowledge leaves irq_req_o low when the enable is later raised. Flag faults appear on flag_o one cycle after the offending event, clear or acknowledge.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    typedef struct packed {
        logic pend;
        logic wake;
    } core_st_t;

    localparam core_st_t CORE_RST = '{pend: 1'b0, wake: 1'b0};

endpackage

// File: rtl/rtc_evt_flag.sv
module rtc_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d, flag_q;

    // set has priority over clear
    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/rtc_irq_core.sv
module rtc_irq_core
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_evt_i,
    input  logic en_i,
    input  logic ack_i,
    input  logic sleep_i,
    output logic pend_o,
    output logic req_o,
    output logic wake_o
);

    core_st_t st_d, st_q;
    logic     take;

    always_comb begin
        st_d = st_q;
        // acknowledge counts only for a request actually presented
        take = ack_i & en_i & st_q.pend;
        if (take)      st_d.pend = 1'b0;
        if (any_evt_i) st_d.pend = 1'b1;
        st_d.wake = sleep_i & st_d.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CORE_RST;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign req_o  = st_q.pend & en_i;
    assign wake_o = st_q.wake;

endmodule

// File: rtl/rtc_irq_wake.sv
module rtc_irq_wake #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] flag_clr_i,
    input  logic               irq_en_i,
    input  logic               irq_ack_i,
    input  logic               sleep_i,
    output logic               irq_req_o,
    output logic               wake_o,
    output logic [NUM_SRC-1:0] flag_o
);

    logic any_evt;
    logic pend_w;

    assign any_evt = |evt_i;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_flag
        rtc_evt_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (evt_i[gi]),
            .clr_i  (flag_clr_i[gi]),
            .flag_o (flag_o[gi])
        );
    end

    rtc_irq_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_evt_i (any_evt),
        .en_i      (irq_en_i),
        .ack_i     (irq_ack_i),
        .sleep_i   (sleep_i),
        .pend_o    (pend_w),
        .req_o     (irq_req_o),
        .wake_o    (wake_o)
    );

endmodule

// File: rtl/rtc_irq_wake_chk.sv
module rtc_irq_wake_chk #(
    parameter int NUM_SRC = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [NUM_SRC-1:0] flag_clr_i,
    input logic               irq_en_i,
    input logic               irq_ack_i,
    input logic               sleep_i,
    input logic               irq_req_o,
    input logic               wake_o,
    input logic [NUM_SRC-1:0] flag_o,
    input logic               pend_w
);

    // R2
    evt_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> pend_w);

    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && irq_ack_i && !(|evt_i)) |=> !pend_w);

    // R5
    masked_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w && !irq_en_i) |=> pend_w);

    // R7
    wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i) |=> !wake_o);

    // R8
    rewake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && pend_w && !(irq_ack_i && irq_en_i)) |=> wake_o);

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_fchk
        // R9
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[gi] |=> flag_o[gi]);
        // R9
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[gi] && !flag_clr_i[gi]) |=> flag_o[gi]);
    end

endmodule

bind rtc_irq_wake rtc_irq_wake_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .flag_clr_i (flag_clr_i),
    .irq_en_i   (irq_en_i),
    .irq_ack_i  (irq_ack_i),
    .sleep_i    (sleep_i),
    .irq_req_o  (irq_req_o),
    .wake_o     (wake_o),
    .flag_o     (flag_o),
    .pend_w     (pend_w)
);

// File: tb/rtc_irq_wake_tb.sv
`timescale 1ns/1ps
module rtc_irq_wake_tb;

    localparam int NSRC  = 2;
    localparam int NROWS = 18;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSRC-1:0] evt_i, flag_clr_i;
    logic            irq_en_i, irq_ack_i, sleep_i;
    logic            irq_req_o, wake_o;
    logic [NSRC-1:0] flag_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rtc_irq_wake #(.NUM_SRC(NSRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .flag_clr_i(flag_clr_i),
        .irq_en_i(irq_en_i), .irq_ack_i(irq_ack_i), .sleep_i(sleep_i),
        .irq_req_o(irq_req_o), .wake_o(wake_o), .flag_o(flag_o)
    );

    // row: {evt[1:0], clr[1:0], en, ack, slp, exp_irq, exp_wake, exp_flags[1:0]}
    localparam logic [10:0] VEC [NROWS] = '{
        11'b01_00_100_10_01, // R2 event latches, presented
        11'b00_00_110_00_01, // R4 ack clears, R9 flag kept
        11'b10_00_000_00_11, // R3 masked event
        11'b00_00_000_00_11, // R3 held while masked
        11'b00_00_010_00_11, // R5 masked ack ignored
        11'b00_00_100_10_11, // R3 presented on enable
        11'b00_00_101_11_11, // R7 sleep with pending wakes
        11'b00_00_100_10_11, // R7 no sleep no wake
        11'b00_00_101_11_11, // R8 rewake on new attempt
        11'b01_00_111_11_11, // R6 event and ack together
        11'b00_00_110_00_11, // R4 ack clears
        11'b00_00_001_00_11, // R8 serviced, no wake
        11'b00_01_000_00_10, // R9 clear source 0
        11'b01_01_000_00_11, // R9 set wins over clear
        11'b11_00_101_11_11, // R10 two sources together
        11'b00_00_110_00_11, // R10 single ack clears
        11'b00_11_000_00_00, // R9 clear both
        11'b00_00_110_00_00  // R5 ack with nothing pending
    };

    task automatic chk(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] ev, input logic [1:0] cl,
                         input logic en, input logic ak, input logic sl);
        evt_i = ev; flag_clr_i = cl; irq_en_i = en; irq_ack_i = ak; sleep_i = sl;
    endtask

    task automatic idle_all();
        drive(2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        idle_all();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 during reset, even with stimulus pending
        drive(2'b11, 2'b00, 1'b1, 1'b0, 1'b1);
        @(posedge clk); #1;
        chk("R1", "in reset", {irq_req_o, wake_o, flag_o}, 4'b0000);
        idle_all();
        @(posedge clk); #1;
        rst_n = 1'b1;
        chk("R1", "after release", {irq_req_o, wake_o, flag_o}, 4'b0000);

        for (int r = 0; r < NROWS; r++) begin
            drive(VEC[r][10:9], VEC[r][8:7], VEC[r][6], VEC[r][5], VEC[r][4]);
            @(posedge clk); #1;
            n_cmp++;
            if ({irq_req_o, wake_o, flag_o} !== VEC[r][3:0]) begin
                n_bad++;
                $display("FAIL R%0d row %0d: actual %b expected %b",
                         (r < 2) ? 2 : 0, r, {irq_req_o, wake_o, flag_o}, VEC[r][3:0]);
            end
        end

        // R7 sleeping with nothing pending, then an event arrives
        drive(2'b00, 2'b00, 1'b0, 1'b0, 1'b1);
        @(posedge clk); #1;
        chk("R7", "sleep idle", {3'b000, wake_o}, 4'b0000);
        drive(2'b10, 2'b00, 1'b0, 1'b0, 1'b1);
        @(posedge clk); #1;
        chk("R7", "event in sleep", {irq_req_o, wake_o, flag_o}, 4'b0110);
        // R8 masked pending keeps waking
        drive(2'b00, 2'b00, 1'b0, 1'b1, 1'b1);
        @(posedge clk); #1;
        chk("R8", "masked ack still wakes", {irq_req_o, wake_o, flag_o}, 4'b0110);

        // R1 reset mid-operation clears everything
        rst_n = 1'b0;
        idle_all();
        @(posedge clk); #1;
        chk("R1", "mid reset", {irq_req_o, wake_o, flag_o}, 4'b0000);
        rst_n = 1'b1;
        drive(2'b00, 2'b00, 1'b1, 1'b0, 1'b1);
        @(posedge clk); #1;
        chk("R1", "nothing pending after reset", {irq_req_o, wake_o, flag_o}, 4'b0000);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule